// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block sits between a 16-bit register port and the pins of a raw 8-bit NAND flash device. Software first loads a command byte or an address byte into a holding register. It then writes a single operation bit into the trigger register. The sequencer drives exactly one bus phase and stops. That phase is one of: a command latch, an address latch, a full page program from an external byte buffer, a full page read into that buffer, an ID read, or a status read.

When the phase ends, a sticky completion flag is raised. This flag drives an interrupt line, which can be masked. The ready/busy line of the device is watched by the block itself. A page read waits for the device to report ready before the first byte is fetched. A page program waits for ready before it reports completion. Software therefore never samples ready/busy.

The same register port also provides the following:
- a chip-enable switch and a 2-bit select that decodes onto four active-low chip enables;
- a pages-per-block code;
- a self-clearing soft reset that aborts the running phase.

Top module: `nand_op_sequencer`

Register map, by `reg_addr`: 0 = trigger, 1 = configuration, 2 = command holding, 3 = address holding, 4 = buffer select.

## Requirements
- R1: After reset, the following hold:
  - the trigger and configuration registers read 0;
  - `irq` is 0 and all `nand_ce_n` bits are 1;
  - `nand_we_n` and `nand_re_n` are 1.
- R2: Writing trigger bit 0 runs a command latch. `nand_cle` is high, and `nand_dq_out` carries the low byte of the command register during exactly one `nand_we_n` low pulse of `PULSE_CLKS` clocks. Afterwards the trigger register reads 0x8000: bit 15 is set and the operation bit is cleared.
- R3: Writing trigger bit 1 runs an address latch. One `nand_we_n` pulse is made with `nand_ale` high, and `nand_dq_out` carries the low byte of the address register.
- R4: The trigger bits mean:
  - bit 0: command;
  - bit 1: address;
  - bit 2: program;
  - bit 3: read;
  - bit 4: ID;
  - bit 5: status.

  When several bits are written at once, only the lowest set bit is run, and the trigger register shows only that bit while it runs.
- R5: A trigger write made while an operation is in progress is ignored. The running bit stays as read back, and no extra bus phase appears.
- R6: Bit 15 of the trigger register stays set until software writes the trigger register with bit 15 at 0. Writing bit 15 as 1 never sets it.
- R7: `irq` is high exactly while bit 15 is set and configuration bit 4 (the mask) is 0. The mask does not stop bit 15 from being set.
- R8: Writing configuration bit 6 as 1 starts a soft reset. Bit 6 reads 1 for `RESET_CYCLES` clocks and then reads 0. The running operation is aborted without a bus phase or a completion flag, and the trigger register reads 0.
- R9: While configuration bit 7 is 1, exactly one `nand_ce_n[k]` is low, where k is the value of buffer-select bits 6:5. While bit 7 is 0, all enables are high.
- R10: A page program sends `PAGE_BYTES+SPARE_BYTES` bytes on `nand_we_n` pulses, taken from `buf_rdata` at `buf_addr` 0, 1, 2 and so on. It sets bit 15 only after `nand_rb` is high.
- R11: A page read waits for `nand_rb` high. It then makes `PAGE_BYTES+SPARE_BYTES` `nand_re_n` pulses. On the last low clock of pulse k, it writes `nand_dq_in` into the buffer at address k through `buf_we`.
- R12: An ID read captures `ID_BYTES` bytes into buffer addresses starting at 0. A status read captures one byte into buffer address 0.
- R13: Starting a program, read, ID or status operation clears buffer-select bits 2:0 to 0. The chip select in bits 6:5 is kept.
- R14: Configuration bits 10:9 hold a pages-per-block code, where 0 to 3 stand for 32, 64, 128 and 256 pages. The code reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| nand_ce_n | output | 4 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven toward the device |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Data from the device |
| nand_rb | input | 1 | Ready (1) / busy (0), synchronous to `clk` |
| buf_addr | output | clog2(PAGE_BYTES+SPARE_BYTES) | Byte index into the external buffer |
| buf_wdata | output | 8 | Byte written into the buffer |
| buf_we | output | 1 | Buffer write strobe |
| buf_rdata | input | 8 | Buffer byte at `buf_addr` |

## Verification
The bench builds the block with the following parameters:
- `PAGE_BYTES=16` and `SPARE_BYTES=4`, so a full page transfer is 20 strobes;
- `ID_BYTES=3`;
- `PULSE_CLKS=2`, so every pulse width is counted against a value of 2;
- `RESET_CYCLES=5`.

With these small values, full program and read transfers can be checked byte by byte against their last buffer index. The bench can also hold ready/busy low across a whole transfer, which exposes the ignored trigger write and the soft-reset abort. The short reset count lets the self-clearing bit be observed both before and after it drops.

// File: rtl/nfs_pkg.sv
// Package: shared codes of the NAND operation sequencer.
// Assumes: the trigger bit order is fixed, because software encodes operations by it.
package nfs_pkg;
    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADDR = 3'd1,
        OP_PROG = 3'd2,
        OP_READ = 3'd3,
        OP_ID   = 3'd4,
        OP_STAT = 3'd5
    } nand_op_e;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_CFG  = 3'd1;
    localparam logic [2:0] RA_CMD  = 3'd2;
    localparam logic [2:0] RA_ADDR = 3'd3;
    localparam logic [2:0] RA_BUF  = 3'd4;

    localparam int CS_W  = 2;
    localparam int CHIPS = 1 << CS_W;
endpackage

// File: rtl/nfs_regs.sv
// Module: register file and operation dispatch.
// It holds the command, address, configuration and buffer-select registers.
// It picks the lowest written trigger bit and starts the engine while idle.
// It keeps the sticky done flag and counts down the soft reset.
// Assumes: RESET_CYCLES >= 1, and a single write port with no read side effects.
module nfs_regs
    import nfs_pkg::*;
#(
    parameter int RESET_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [15:0]     reg_wdata,
    output logic [15:0]     reg_rdata,
    input  logic            eng_busy,
    input  logic            eng_done,
    output logic            start_o,
    output nand_op_e        op_o,
    output logic            abort_o,
    output logic [7:0]      cmd_o,
    output logic [7:0]      addr_o,
    output logic [CS_W-1:0] cs_o,
    output logic            ce_en_o,
    output logic            irq_o
);
    localparam int RCW = $clog2(RESET_CYCLES + 1);

    logic [15:0]     cmd_q, addr_q;
    logic [5:0]      ops_q;
    logic            done_q, mask_q, ce_q;
    logic [1:0]      ppb_q;
    logic [2:0]      bsel_q;
    logic [CS_W-1:0] cs_q;
    logic [RCW-1:0]  rst_cnt;
    logic            rst_act, wr_ctrl, idle, srst_req;

    // Returns the index of the lowest set trigger bit.
    function automatic logic [2:0] lowest(input logic [5:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 5; i >= 0; i--)
            if (v[i]) r = 3'(i);
        return r;
    endfunction

    // Decodes write qualifiers and the engine start.
    always_comb begin
        rst_act  = (rst_cnt != '0);
        wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
        idle     = !eng_busy && (ops_q == 6'd0) && !rst_act;
        start_o  = wr_ctrl && idle && (|reg_wdata[5:0]);
        op_o     = nand_op_e'(lowest(reg_wdata[5:0]));
        srst_req = reg_we && (reg_addr == RA_CFG) && reg_wdata[6] && !rst_act;
    end

    // Updates the register state, the done flag and the reset counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            ops_q   <= '0;
            done_q  <= 1'b0;
            mask_q  <= 1'b0;
            ce_q    <= 1'b0;
            ppb_q   <= '0;
            bsel_q  <= '0;
            cs_q    <= '0;
            rst_cnt <= '0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    RA_CMD:  cmd_q  <= reg_wdata;
                    RA_ADDR: addr_q <= reg_wdata;
                    RA_CFG: begin
                        mask_q <= reg_wdata[4];
                        ce_q   <= reg_wdata[7];
                        ppb_q  <= reg_wdata[10:9];
                    end
                    RA_BUF: begin
                        bsel_q <= reg_wdata[2:0];
                        cs_q   <= reg_wdata[6:5];
                    end
                    default: ;
                endcase
            end
            if (srst_req)
                rst_cnt <= RCW'(RESET_CYCLES);
            else if (rst_act)
                rst_cnt <= rst_cnt - 1'b1;
            if (rst_act) begin
                ops_q  <= '0;
                done_q <= 1'b0;
            end else if (eng_done) begin
                ops_q  <= '0;
                done_q <= 1'b1;
            end else if (wr_ctrl && idle) begin
                ops_q  <= start_o ? (6'd1 << op_o) : 6'd0;
                done_q <= done_q & reg_wdata[15];
            end
            if (start_o && (op_o >= OP_PROG))
                bsel_q <= '0;
        end
    end

    // Selects the read data and drives the outputs derived from the registers.
    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {done_q, 9'd0, ops_q};
            RA_CFG:  reg_rdata = {5'd0, ppb_q, 1'b0, ce_q, rst_act, 1'b0, mask_q, 4'd0};
            RA_CMD:  reg_rdata = cmd_q;
            RA_ADDR: reg_rdata = addr_q;
            RA_BUF:  reg_rdata = {9'd0, cs_q, 2'd0, bsel_q};
            default: reg_rdata = 16'd0;
        endcase
        abort_o = rst_act;
        cmd_o   = cmd_q[7:0];
        addr_o  = addr_q[7:0];
        cs_o    = cs_q;
        ce_en_o = ce_q;
        irq_o   = done_q & ~mask_q;
    end
endmodule

// File: rtl/nfs_engine.sv
// Module: NAND bus phase engine.
// It runs one latch or data transfer as a train of strobe pulses.
// Each pulse is PULSE_CLKS clocks low and then PULSE_CLKS clocks high.
// A read waits for ready before it starts; a program waits for ready after its last byte.
// Assumes: nand_rb is synchronous to clk, buf_rdata is combinational from buf_addr,
// and ID_BYTES <= PAGE_BYTES + SPARE_BYTES.
module nfs_engine
    import nfs_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int ID_BYTES    = 5,
    parameter int PULSE_CLKS  = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        abort,
    input  logic                                        start,
    input  nand_op_e                                    op,
    input  logic [7:0]                                  cmd_byte,
    input  logic [7:0]                                  addr_byte,
    output logic                                        busy,
    output logic                                        done,
    output logic                                        cle,
    output logic                                        ale,
    output logic                                        we_n,
    output logic                                        re_n,
    output logic [7:0]                                  dq_out,
    output logic                                        dq_oe,
    input  logic [7:0]                                  dq_in,
    input  logic                                        rb,
    output logic [$clog2(PAGE_BYTES+SPARE_BYTES)-1:0]   buf_addr,
    output logic [7:0]                                  buf_wdata,
    output logic                                        buf_we,
    input  logic [7:0]                                  buf_rdata
);
    localparam int XFER = PAGE_BYTES + SPARE_BYTES;
    localparam int IW   = $clog2(XFER);
    localparam int TW   = $clog2(PULSE_CLKS + 1);

    typedef enum logic [2:0] {S_IDLE, S_PRE_RB, S_LOW, S_HIGH, S_POST_RB, S_DONE} st_e;

    st_e            state;
    nand_op_e       op_q;
    logic [IW-1:0]  idx, last_idx;
    logic [TW-1:0]  tcnt;
    logic           is_rd, tend, active;

    // Derives the transfer length and direction of the latched operation.
    always_comb begin
        case (op_q)
            OP_PROG, OP_READ: last_idx = IW'(XFER - 1);
            OP_ID:            last_idx = IW'(ID_BYTES - 1);
            default:          last_idx = '0;
        endcase
        is_rd = (op_q == OP_READ) || (op_q == OP_ID) || (op_q == OP_STAT);
        tend  = (tcnt == TW'(PULSE_CLKS - 1));
    end

    // Steps the phase state machine and the pulse and byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= S_IDLE;
            op_q  <= OP_CMD;
            idx   <= '0;
            tcnt  <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    op_q  <= op;
                    idx   <= '0;
                    tcnt  <= '0;
                    state <= (op == OP_READ) ? S_PRE_RB : S_LOW;
                end
                S_PRE_RB: if (rb) state <= S_LOW;
                S_LOW: begin
                    tcnt <= tend ? '0 : tcnt + 1'b1;
                    if (tend) state <= S_HIGH;
                end
                S_HIGH: begin
                    tcnt <= tend ? '0 : tcnt + 1'b1;
                    if (tend) begin
                        if (idx == last_idx)
                            state <= (op_q == OP_PROG) ? S_POST_RB : S_DONE;
                        else begin
                            idx   <= idx + 1'b1;
                            state <= S_LOW;
                        end
                    end
                end
                S_POST_RB: if (rb) state <= S_DONE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Drives the pins and the buffer port from the current phase.
    always_comb begin
        active    = (state == S_LOW) || (state == S_HIGH);
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        we_n      = !((state == S_LOW) && !is_rd);
        re_n      = !((state == S_LOW) && is_rd);
        cle       = active && (op_q == OP_CMD);
        ale       = active && (op_q == OP_ADDR);
        dq_oe     = active && !is_rd;
        case (op_q)
            OP_CMD:  dq_out = cmd_byte;
            OP_ADDR: dq_out = addr_byte;
            default: dq_out = buf_rdata;
        endcase
        buf_addr  = idx;
        buf_wdata = dq_in;
        buf_we    = (state == S_LOW) && is_rd && tend;
    end
endmodule

// File: rtl/nand_op_sequencer.sv
// Module: top of the NAND operation sequencer.
// It joins the register file and the phase engine, and decodes the chip enables.
// Assumes: a single clock domain, with a synchronous active-low reset.
module nand_op_sequencer
    import nfs_pkg::*;
#(
    parameter int PAGE_BYTES   = 2048,
    parameter int SPARE_BYTES  = 64,
    parameter int ID_BYTES     = 5,
    parameter int PULSE_CLKS   = 2,
    parameter int RESET_CYCLES = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        reg_we,
    input  logic [2:0]                                  reg_addr,
    input  logic [15:0]                                 reg_wdata,
    output logic [15:0]                                 reg_rdata,
    output logic                                        irq,
    output logic [3:0]                                  nand_ce_n,
    output logic                                        nand_cle,
    output logic                                        nand_ale,
    output logic                                        nand_we_n,
    output logic                                        nand_re_n,
    output logic [7:0]                                  nand_dq_out,
    output logic                                        nand_dq_oe,
    input  logic [7:0]                                  nand_dq_in,
    input  logic                                        nand_rb,
    output logic [$clog2(PAGE_BYTES+SPARE_BYTES)-1:0]   buf_addr,
    output logic [7:0]                                  buf_wdata,
    output logic                                        buf_we,
    input  logic [7:0]                                  buf_rdata
);
    logic            eng_start, eng_busy, eng_done, eng_abort, ce_en;
    nand_op_e        eng_op;
    logic [7:0]      cmd_byte, addr_byte;
    logic [CS_W-1:0] cs_sel;

    nfs_regs #(.RESET_CYCLES(RESET_CYCLES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_done(eng_done), .start_o(eng_start), .op_o(eng_op),
        .abort_o(eng_abort), .cmd_o(cmd_byte), .addr_o(addr_byte),
        .cs_o(cs_sel), .ce_en_o(ce_en), .irq_o(irq)
    );

    nfs_engine #(
        .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES),
        .ID_BYTES(ID_BYTES), .PULSE_CLKS(PULSE_CLKS)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .abort(eng_abort), .start(eng_start),
        .op(eng_op), .cmd_byte(cmd_byte), .addr_byte(addr_byte),
        .busy(eng_busy), .done(eng_done), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out),
        .dq_oe(nand_dq_oe), .dq_in(nand_dq_in), .rb(nand_rb),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we),
        .buf_rdata(buf_rdata)
    );

    // Decodes the selected chip onto one active-low enable per chip.
    for (genvar k = 0; k < CHIPS; k++) begin : g_ce
        assign nand_ce_n[k] = !(ce_en && (cs_sel == CS_W'(k)));
    end
endmodule

// File: rtl/nand_op_sequencer_chk.sv
// Module: protocol checker for the NAND operation sequencer, attached by bind.
// Assumes: it observes the top-level pins and the dispatch handshake wires.
module nand_op_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_dq_oe,
    input logic [3:0] nand_ce_n,
    input logic       buf_we,
    input logic       eng_start,
    input logic       eng_busy,
    input logic       eng_done,
    input logic       eng_abort
);
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R3
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R9
    ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));
    // R11
    capture_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (!nand_re_n && !nand_dq_oe));
    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);
    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !eng_busy);
    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !eng_busy);
endmodule

bind nand_op_sequencer nand_op_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_dq_oe(nand_dq_oe),
    .nand_ce_n(nand_ce_n), .buf_we(buf_we), .eng_start(eng_start),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_abort(eng_abort)
);

// File: tb/test_nand_op_sequencer.sv
module test_nand_op_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE = 16, SPARE = 4, IDB = 3, PULSE = 2, RSTC = 5;
    localparam int XFER = PAGE + SPARE;
    localparam int AW = $clog2(XFER);

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0, reg_rdata;
    logic irq, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb = 1'b1;
    logic [3:0] nand_ce_n;
    logic [7:0] nand_dq_out, nand_dq_in, buf_wdata, buf_rdata;
    logic [AW-1:0] buf_addr;
    logic buf_we;

    int n_tests = 0, n_fail = 0, re_cnt = 0;
    bit finished = 0;
    logic [9:0]  exp_bus[$];
    logic [12:0] exp_buf[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign nand_dq_in = 8'hC3 ^ 8'(re_cnt);
    assign buf_rdata  = 8'({3'd0, buf_addr} * 8'd7 + 8'h11);

    nand_op_sequencer #(.PAGE_BYTES(PAGE), .SPARE_BYTES(SPARE), .ID_BYTES(IDB),
        .PULSE_CLKS(PULSE), .RESET_CYCLES(RSTC)) i_nand_op_sequencer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_we(buf_we),
        .buf_rdata(buf_rdata));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected bus bytes on each write strobe and expected buffer writes.
    logic prev_we = 1'b1, prev_re = 1'b1;
    int low_w = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n) low_w++;
            if (nand_we_n && !prev_we) begin
                check("R2 we_n pulse width", low_w, PULSE);
                if (exp_bus.size() == 0)
                    check("R5 unexpected bus byte", {nand_cle, nand_ale, nand_dq_out}, 10'h3FF);
                else
                    check("R2/R3/R10 bus byte", {nand_cle, nand_ale, nand_dq_out}, exp_bus.pop_front());
            end
            if (nand_we_n) low_w = 0;
            if (nand_re_n && !prev_re) re_cnt++;
            if (buf_we) begin
                if (exp_buf.size() == 0)
                    check("R11 unexpected buffer write", {buf_addr, buf_wdata}, 13'h1FFF);
                else
                    check("R11/R12 buffer write", {buf_addr, buf_wdata}, exp_buf.pop_front());
            end
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [15:0] v;
        v = 16'd0;
        for (int i = 0; i < 3000 && !v[15]; i++) begin
            @(negedge clk);
            rd(3'd0, v);
        end
        check(req, v, 16'h8000);
    endtask

    task automatic push_cmd(input logic [7:0] b);  exp_bus.push_back({2'b10, b}); endtask
    task automatic push_addr(input logic [7:0] b); exp_bus.push_back({2'b01, b}); endtask

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, v); check("R1 trigger after reset", v, 16'h0);
        rd(3'd1, v); check("R1 config after reset", v, 16'h0);
        check("R1 irq/ce/strobes", {irq, nand_ce_n, nand_we_n, nand_re_n}, {1'b0, 4'hF, 2'b11});
        // R9 chip enable decode
        wr(3'd4, 16'h0045);
        check("R9 ce disabled", nand_ce_n, 4'hF);
        wr(3'd1, 16'h0080);
        check("R9 ce for cs 2", nand_ce_n, 4'b1011);
        // R2 command latch, R7 irq
        wr(3'd2, 16'h1234); push_cmd(8'h34);
        wr(3'd0, 16'h0001);
        wait_done("R2 command done");
        check("R7 irq on done", irq, 1'b1);
        // R6 sticky flag
        wr(3'd0, 16'h8000);
        rd(3'd0, v); check("R6 writing 1 keeps flag", v, 16'h8000);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); check("R6 cleared by 0", v, 16'h0);
        check("R7 irq low after clear", irq, 1'b0);
        // R3 address latch
        wr(3'd3, 16'hBEEF); push_addr(8'hEF);
        wr(3'd0, 16'h0002);
        wait_done("R3 address done");
        wr(3'd0, 16'h0);
        // R4 lowest bit wins
        wr(3'd2, 16'h0090); push_cmd(8'h90);
        wr(3'd0, 16'h0003);
        rd(3'd0, v); check("R4 only lowest bit runs", v, 16'h0001);
        wait_done("R4 done");
        check("R4 no address phase", exp_bus.size(), 0);
        wr(3'd0, 16'h0);
        // R12 ID read, R13 buffer select cleared
        wr(3'd4, 16'h0045);
        re_cnt = 0;
        for (int k = 0; k < IDB; k++) exp_buf.push_back({AW'(k), 8'hC3 ^ 8'(k)});
        wr(3'd0, 16'h0030);
        wait_done("R12 ID done");
        check("R12 ID bytes", exp_buf.size(), 0);
        rd(3'd4, v); check("R13 buffer select cleared, cs kept", v, 16'h0040);
        wr(3'd0, 16'h0);
        // R12 status read
        re_cnt = 0; exp_buf.push_back({AW'(0), 8'hC3});
        wr(3'd0, 16'h0020);
        wait_done("R12 status done");
        check("R12 status byte", exp_buf.size(), 0);
        wr(3'd0, 16'h0);
        // R11 page read waits for ready
        nand_rb = 1'b0; re_cnt = 0;
        for (int k = 0; k < XFER; k++) exp_buf.push_back({AW'(k), 8'hC3 ^ 8'(k)});
        wr(3'd0, 16'h0008);
        repeat (30) @(negedge clk);
        check("R11 no strobe while busy", re_cnt, 0);
        rd(3'd0, v); check("R11 still running", v, 16'h0008);
        nand_rb = 1'b1;
        wait_done("R11 read done");
        check("R11 all bytes captured", exp_buf.size(), 0);
        wr(3'd0, 16'h0);
        // R10 page program, R5 write ignored while busy
        nand_rb = 1'b0;
        for (int k = 0; k < XFER; k++) exp_bus.push_back({2'b00, 8'(k * 7 + 17)});
        wr(3'd0, 16'h0004);
        for (int i = 0; i < 500 && exp_bus.size() != 0; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        rd(3'd0, v); check("R10 no done before ready", v, 16'h0004);
        wr(3'd0, 16'h0002);
        rd(3'd0, v); check("R5 busy write ignored", v, 16'h0004);
        nand_rb = 1'b1;
        wait_done("R10 program done");
        check("R10 all bytes sent", exp_bus.size(), 0);
        wr(3'd0, 16'h0);
        // R7 mask
        wr(3'd1, 16'h0090); push_cmd(8'h90);
        wr(3'd0, 16'h0001);
        wait_done("R7 flag sets while masked");
        check("R7 irq masked", irq, 1'b0);
        wr(3'd1, 16'h0080);
        check("R7 irq after unmask", irq, 1'b1);
        wr(3'd0, 16'h0);
        // R14 pages-per-block code
        wr(3'd1, 16'h0680);
        rd(3'd1, v); check("R14 ppb readback", v, 16'h0680);
        // R8 soft reset aborts a waiting read
        nand_rb = 1'b0; re_cnt = 0;
        wr(3'd0, 16'h0008);
        repeat (5) @(negedge clk);
        wr(3'd1, 16'h06C0);
        rd(3'd1, v); check("R8 reset bit reads 1", v, 16'h06C0);
        repeat (RSTC + 2) @(negedge clk);
        rd(3'd1, v); check("R8 reset bit self-clears", v, 16'h0680);
        rd(3'd0, v); check("R8 operation aborted", v, 16'h0);
        nand_rb = 1'b1;
        repeat (20) @(negedge clk);
        check("R8 no read strobes after abort", re_cnt, 0);
        rd(3'd0, v); check("R8 no done after abort", v, 16'h0);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule